// File: doc/BRIEF.md
# Priority Interrupt Acknowledge Controller

This controller gathers a set of maskable interrupt request lines and a single non-maskable input. It keeps a pending flag for every maskable source. Each source also has an enable bit and a priority level, both written through a small configuration port. From these it continuously selects one winner. Whenever a winner exists and the post-reset gate has opened, the controller raises a single interrupt line toward the core.

The core fetches the winner through an acknowledge read. This read is not a plain lookup: it returns the winner's number and level, and in the same cycle it clears that winner's pending flag. The clear happens for every read, whether or not an interrupt sequence is actually in progress.

The non-maskable pin is idle high and active on its falling edge. It passes through a two-stage synchronizer and then a width filter, so glitches never register as an NMI. Once qualified, an NMI beats every maskable request, and no enable or level setting can suppress it. For the whole of the first instruction after reset, the interrupt line stays low. While the synchronized pin is low, the stop-mode enable bit is held at zero.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset:
  - all pending flags, enables and levels are 0;
  - `irq_o` is 0;
  - `ack_none_o` is 1 with `ack_num_o` and `ack_lvl_o` at 0;
  - `stop_en_o` is 0;
  - the filtered NMI level is high.
- R2: Among eligible sources, the winner is the one with the highest level. A source is eligible when it is pending, its enable is 1 and its level is not 0. When levels tie, the lower source number wins.
- R3: A cycle with `ack_rd_i` high makes the cycle-before-edge winner visible on the cycle after. If that winner is maskable, `ack_num_o` shows its number, `ack_lvl_o` shows its level and `ack_none_o` is 0, and its pending flag clears. If a request for the same source arrives in that same cycle, the flag stays set.
- R4: An acknowledge read with no winner sets `ack_none_o` to 1 and drives `ack_num_o` and `ack_lvl_o` to 0. It clears nothing.
- R5: A source whose enable is 0, or whose level is 0, neither raises `irq_o` nor wins an acknowledge. Its pending flag is kept, so it competes as soon as it becomes eligible.
- R6: A qualified falling edge of the filtered NMI level sets an NMI pending flag, regardless of any configuration. While that flag is set, the NMI is the winner. An acknowledge read of the NMI returns number `N_SRC` with level all ones and clears only the NMI flag.
- R7: The filtered NMI level follows the synchronized pin only after the pin has held its new value for `NMI_MARGIN_CYC+2` consecutive cycles. Shorter low phases and shorter high phases are both ignored.
- R8: `irq_o` stays 0 until the first `retire_i` pulse after reset. From the cycle after that pulse on, the gate remains open.
- R9: Once the gate is open, `irq_o` is 1 exactly when a winner (maskable or NMI) exists.
- R10: A `stop_wr_i` pulse loads `stop_wdata_i` into `stop_en_o` on the next cycle, but only while the synchronized NMI level is high. While that level is low, `stop_en_o` is forced to 0 and writes of 1 are lost.
- R11: `nmi_lvl_o` shows the NMI pin level through a two-register synchronizer, so it lags the pin by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | N_SRC | Maskable request lines, one per source; high sets the pending flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | $clog2(N_SRC) | Source addressed by the configuration write |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_lvl_i | input | PRIO_W | Priority level to write (0 means disabled) |
| ack_rd_i | input | 1 | Acknowledge read strobe, with a clear side effect |
| ack_num_o | output | $clog2(N_SRC+1) | Number returned by the last acknowledge (N_SRC for NMI) |
| ack_lvl_o | output | PRIO_W | Level returned by the last acknowledge |
| ack_none_o | output | 1 | The last acknowledge found no winner |
| irq_o | output | 1 | Interrupt request to the core |
| retire_i | input | 1 | Instruction-retire strobe |
| nmi_pin_i | input | 1 | Asynchronous NMI pin, active falling edge |
| nmi_lvl_o | output | 1 | Synchronized NMI pin level |
| stop_wr_i | input | 1 | Stop-enable write strobe |
| stop_wdata_i | input | 1 | Stop-enable value to write |
| stop_en_o | output | 1 | Stop-mode enable bit |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of mistake.

- **Post-reset gate.** A request is pending before the first retire. A design that ignored the gate would raise the interrupt line too early.
- **Tied levels and disabled sources.** Two sources share a level, and other sources are pending but have enable 0 or level 0. A wrong tie-break or a missing eligibility mask returns the wrong number.
- **Read with nothing eligible.** The bench follows it with a later enable of the hidden source. A design that cleared a flag on an empty read loses that request.
- **NMI filter.** Low glitches and high glitches are both one cycle shorter than the qualification window. A filter that is off by one either fires a spurious NMI or misses a real one.
- **Stop-enable write while NMI is low.** A design that did not force the bit would show it set.

A long randomized stretch is compared every cycle against a behavioural model.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    // Which kind of source currently wins arbitration.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_MASK = 2'd1,
        WIN_NMI  = 2'd2
    } win_kind_e;

endpackage

// File: rtl/irq_nmi_filter.sv
// Two-register synchronizer followed by a width qualifier.
module irq_nmi_filter #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_sync_o,
    output logic filt_o,
    output logic fall_o
);
    localparam int CNT_W = $clog2(QUAL + 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             filt;
        logic [CNT_W-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    differ;
    logic    flip;

    always_comb begin
        st_d   = st_q;
        differ = st_q.s2 != st_q.filt;
        flip   = differ && (st_q.cnt == CNT_W'(QUAL - 1));
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        if (flip) begin
            st_d.filt = st_q.s2;
            st_d.cnt  = '0;
        end else if (differ) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
        end else begin
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= 1'b1;
            st_q.s2   <= 1'b1;
            st_q.filt <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_sync_o = st_q.s2;
    assign filt_o     = st_q.filt;
    // Qualified high-to-low transition, taking effect at this edge.
    assign fall_o     = flip && !st_q.s2;

endmodule

// File: rtl/irq_src_bank.sv
// Pending flags plus per-source enable and level registers.
module irq_src_bank #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = $clog2(N_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              req_i,
    input  logic                          cfg_wr_i,
    input  logic [IDX_W-1:0]              cfg_idx_i,
    input  logic                          cfg_en_i,
    input  logic [PRIO_W-1:0]             cfg_lvl_i,
    input  logic                          clr_vld_i,
    input  logic [IDX_W-1:0]              clr_idx_i,
    output logic [N_SRC-1:0]              pend_o,
    output logic [N_SRC-1:0]              elig_o,
    output logic [N_SRC-1:0][PRIO_W-1:0]  lvl_o
);
    typedef struct packed {
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0][PRIO_W-1:0] lvl;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [N_SRC-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (clr_vld_i) begin
            clr_mask = N_SRC'(1) << clr_idx_i;
        end
        // A fresh request in the clearing cycle wins over the clear.
        st_d.pend = (st_q.pend & ~clr_mask) | req_i;
        if (cfg_wr_i && (int'(cfg_idx_i) < N_SRC)) begin
            st_d.en[cfg_idx_i]  = cfg_en_i;
            st_d.lvl[cfg_idx_i] = cfg_lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig_o[g] = st_q.pend[g] & st_q.en[g] & (|st_q.lvl[g]);
    end

    assign pend_o = st_q.pend;
    assign lvl_o  = st_q.lvl;

endmodule

// File: rtl/irq_prio_pick.sv
// Combinational winner search: highest level, lowest number on a tie.
module irq_prio_pick #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             elig_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] lvl_i,
    output logic                         vld_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic [PRIO_W-1:0]            lvl_o
);
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!vld_o || (lvl_i[i] > lvl_o))) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int N_SRC          = 8,
    parameter int PRIO_W         = 3,
    parameter int NMI_MARGIN_CYC = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             irq_req_i,
    input  logic                         cfg_wr_i,
    input  logic [$clog2(N_SRC)-1:0]     cfg_idx_i,
    input  logic                         cfg_en_i,
    input  logic [PRIO_W-1:0]            cfg_lvl_i,
    input  logic                         ack_rd_i,
    output logic [$clog2(N_SRC+1)-1:0]   ack_num_o,
    output logic [PRIO_W-1:0]            ack_lvl_o,
    output logic                         ack_none_o,
    output logic                         irq_o,
    input  logic                         retire_i,
    input  logic                         nmi_pin_i,
    output logic                         nmi_lvl_o,
    input  logic                         stop_wr_i,
    input  logic                         stop_wdata_i,
    output logic                         stop_en_o
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int NUM_W = $clog2(N_SRC + 1);
    localparam int QUAL  = NMI_MARGIN_CYC + 2;

    typedef struct packed {
        logic              gate;
        logic              stop;
        logic              nmi_pend;
        logic [NUM_W-1:0]  ack_num;
        logic [PRIO_W-1:0] ack_lvl;
        logic              ack_none;
    } ctl_st_t;

    ctl_st_t                     st_d, st_q;
    win_kind_e                   win_kind;
    logic                        win_any;
    logic [N_SRC-1:0]            pend_w;
    logic [N_SRC-1:0]            elig_w;
    logic [N_SRC-1:0][PRIO_W-1:0] lvl_w;
    logic                        pick_vld;
    logic [IDX_W-1:0]            pick_idx;
    logic [PRIO_W-1:0]           pick_lvl;
    logic                        nmi_sync;
    logic                        nmi_filt;
    logic                        nmi_fall;
    logic                        clr_vld;

    irq_nmi_filter #(.QUAL(QUAL)) u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (nmi_pin_i),
        .lvl_sync_o (nmi_sync),
        .filt_o     (nmi_filt),
        .fall_o     (nmi_fall)
    );

    irq_src_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (irq_req_i),
        .cfg_wr_i  (cfg_wr_i),
        .cfg_idx_i (cfg_idx_i),
        .cfg_en_i  (cfg_en_i),
        .cfg_lvl_i (cfg_lvl_i),
        .clr_vld_i (clr_vld),
        .clr_idx_i (pick_idx),
        .pend_o    (pend_w),
        .elig_o    (elig_w),
        .lvl_o     (lvl_w)
    );

    irq_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .elig_i (elig_w),
        .lvl_i  (lvl_w),
        .vld_o  (pick_vld),
        .idx_o  (pick_idx),
        .lvl_o  (pick_lvl)
    );

    always_comb begin
        if (st_q.nmi_pend)  win_kind = WIN_NMI;
        else if (pick_vld)  win_kind = WIN_MASK;
        else                win_kind = WIN_NONE;
        win_any = win_kind != WIN_NONE;
        clr_vld = ack_rd_i && (win_kind == WIN_MASK);
    end

    always_comb begin
        st_d = st_q;
        if (retire_i) begin
            st_d.gate = 1'b1;
        end
        if (ack_rd_i) begin
            unique case (win_kind)
                WIN_NMI: begin
                    st_d.ack_num  = NUM_W'(N_SRC);
                    st_d.ack_lvl  = '1;
                    st_d.ack_none = 1'b0;
                    st_d.nmi_pend = 1'b0;
                end
                WIN_MASK: begin
                    st_d.ack_num  = NUM_W'(pick_idx);
                    st_d.ack_lvl  = pick_lvl;
                    st_d.ack_none = 1'b0;
                end
                default: begin
                    st_d.ack_num  = '0;
                    st_d.ack_lvl  = '0;
                    st_d.ack_none = 1'b1;
                end
            endcase
        end
        if (nmi_fall) begin
            st_d.nmi_pend = 1'b1;
        end
        if (!nmi_sync) begin
            st_d.stop = 1'b0;
        end else if (stop_wr_i) begin
            st_d.stop = stop_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ack_none <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.gate && win_any;
    assign ack_num_o  = st_q.ack_num;
    assign ack_lvl_o  = st_q.ack_lvl;
    assign ack_none_o = st_q.ack_none;
    assign nmi_lvl_o  = nmi_sync;
    assign stop_en_o  = st_q.stop;

endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
    parameter int N_SRC = 8,
    parameter int NUM_W = 4,
    parameter int IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 retire_i,
    input logic                 ack_rd_i,
    input logic [N_SRC-1:0]     irq_req_i,
    input logic                 irq_o,
    input logic                 stop_en_o,
    input logic                 nmi_lvl_o,
    input logic                 ack_none_o,
    input logic [NUM_W-1:0]     ack_num_o,
    input logic                 win_any,
    input logic                 nmi_pend,
    input logic                 pick_vld,
    input logic [IDX_W-1:0]     pick_idx,
    input logic [N_SRC-1:0]     pend
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (retire_i) seen_q <= 1'b1;
    end

    p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !irq_o);

    p_stop_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_lvl_o |=> !stop_en_o);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !win_any |=> ack_none_o);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !nmi_pend && pick_vld && !irq_req_i[pick_idx]
        |=> !pend[$past(pick_idx)]);

    p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && nmi_pend |=> (ack_num_o == NUM_W'(N_SRC)) && !ack_none_o);

endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
    .N_SRC (N_SRC),
    .NUM_W ($clog2(N_SRC + 1)),
    .IDX_W ($clog2(N_SRC))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_i),
    .ack_rd_i   (ack_rd_i),
    .irq_req_i  (irq_req_i),
    .irq_o      (irq_o),
    .stop_en_o  (stop_en_o),
    .nmi_lvl_o  (nmi_lvl_o),
    .ack_none_o (ack_none_o),
    .ack_num_o  (ack_num_o),
    .win_any    (win_any),
    .nmi_pend   (st_q.nmi_pend),
    .pick_vld   (pick_vld),
    .pick_idx   (pick_idx),
    .pend       (pend_w)
);

// File: tb/irq_ack_ctrl_bench.sv
module irq_ack_ctrl_bench;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int MG = 2;
    localparam int Q  = MG + 2;
    localparam int NW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req_i = '0;
    logic          cfg_wr_i = 1'b0;
    logic [IW-1:0] cfg_idx_i = '0;
    logic          cfg_en_i = 1'b0;
    logic [PW-1:0] cfg_lvl_i = '0;
    logic          ack_rd_i = 1'b0;
    logic [NW-1:0] ack_num_o;
    logic [PW-1:0] ack_lvl_o;
    logic          ack_none_o;
    logic          irq_o;
    logic          retire_i = 1'b0;
    logic          nmi_pin_i = 1'b1;
    logic          nmi_lvl_o;
    logic          stop_wr_i = 1'b0;
    logic          stop_wdata_i = 1'b0;
    logic          stop_en_o;

    always #4 clk = ~clk;

    irq_ack_ctrl #(.N_SRC(N), .PRIO_W(PW), .NMI_MARGIN_CYC(MG)) u_irq_ack_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i),
        .cfg_wr_i(cfg_wr_i), .cfg_idx_i(cfg_idx_i), .cfg_en_i(cfg_en_i),
        .cfg_lvl_i(cfg_lvl_i), .ack_rd_i(ack_rd_i), .ack_num_o(ack_num_o),
        .ack_lvl_o(ack_lvl_o), .ack_none_o(ack_none_o), .irq_o(irq_o),
        .retire_i(retire_i), .nmi_pin_i(nmi_pin_i), .nmi_lvl_o(nmi_lvl_o),
        .stop_wr_i(stop_wr_i), .stop_wdata_i(stop_wdata_i), .stop_en_o(stop_en_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_pend[N];
    int m_en[N];
    int m_lvl[N];
    int m_gate, m_stop, m_nmi, m_filt, m_run;
    int m_hist[$];
    int m_num, m_alvl, m_none;

    function automatic int m_winner();
        int best = -1;
        if (m_nmi != 0) return N;
        foreach (m_pend[i]) begin
            if (m_pend[i] != 0 && m_en[i] != 0 && m_lvl[i] != 0) begin
                if (best < 0) best = i;
                else if (m_lvl[i] > m_lvl[best]) best = i;
            end
        end
        return best;
    endfunction

    function automatic int m_sync();
        return m_hist[1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
            m_gate = 0; m_stop = 0; m_nmi = 0; m_filt = 1; m_run = 0;
            m_hist = '{1, 1};
            m_num = 0; m_alvl = 0; m_none = 1;
        end else begin
            int w;
            int s;
            w = m_winner();
            s = m_sync();
            if (ack_rd_i) begin
                if (w < 0) begin m_num = 0; m_alvl = 0; m_none = 1; end
                else if (w == N) begin m_num = N; m_alvl = (1 << PW) - 1; m_none = 0; m_nmi = 0; end
                else begin m_num = w; m_alvl = m_lvl[w]; m_none = 0; m_pend[w] = 0; end
            end
            for (int i = 0; i < N; i++) if (irq_req_i[i]) m_pend[i] = 1;
            if (cfg_wr_i) begin
                m_en[cfg_idx_i]  = int'(cfg_en_i);
                m_lvl[cfg_idx_i] = int'(cfg_lvl_i);
            end
            // length of the current disagreement run decides the filter
            if (s != m_filt) begin
                m_run++;
                if (m_run >= Q) begin
                    m_filt = s; m_run = 0;
                    if (s == 0) m_nmi = 1;
                end
            end else m_run = 0;
            if (s == 0) m_stop = 0;
            else if (stop_wr_i) m_stop = int'(stop_wdata_i);
            if (retire_i) m_gate = 1;
            m_hist.pop_back();
            m_hist.push_front(int'(nmi_pin_i));
        end
    end

    // Per-cycle comparison, away from the active edge.
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(irq_o), (m_gate != 0 && m_winner() >= 0) ? 1 : 0, "R9 irq_o");
            check(int'(ack_none_o), m_none, "R3 ack_none_o");
            check(int'(ack_num_o), m_num, "R3 ack_num_o");
            check(int'(ack_lvl_o), m_alvl, "R3 ack_lvl_o");
            check(int'(stop_en_o), m_stop, "R10 stop_en_o");
            check(int'(nmi_lvl_o), m_sync(), "R11 nmi_lvl_o");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int idx, input bit en, input int lvl);
        cfg_wr_i = 1'b1; cfg_idx_i = IW'(idx); cfg_en_i = en; cfg_lvl_i = PW'(lvl);
        tick();
        cfg_wr_i = 1'b0;
    endtask

    task automatic req(input logic [N-1:0] v);
        irq_req_i = v; tick(); irq_req_i = '0;
    endtask

    task automatic ack(input int en, input int el, input int enone, input string tag);
        ack_rd_i = 1'b1; tick(); ack_rd_i = 1'b0;
        check(int'(ack_num_o), en, tag);
        check(int'(ack_lvl_o), el, tag);
        check(int'(ack_none_o), enone, tag);
    endtask

    task automatic nmi_phase(input bit lvl, input int cyc);
        nmi_pin_i = lvl; tick(cyc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        cmp_on = 1'b1;
        // R1 reset state
        check(int'(irq_o), 0, "R1 irq after reset");
        check(int'(ack_none_o), 1, "R1 ack_none after reset");
        check(int'(stop_en_o), 0, "R1 stop after reset");
        check(int'(nmi_lvl_o), 1, "R1 nmi level after reset");

        // R8: pending source before the first retire
        cfg(3, 1'b1, 5);
        req(8'h08);
        tick(2);
        check(int'(irq_o), 0, "R8 gate closed");
        retire_i = 1'b1; tick(); retire_i = 1'b0;
        check(int'(irq_o), 1, "R8 R9 gate open");
        ack(3, 5, 0, "R3 read returns winner");
        check(int'(irq_o), 0, "R3 pending cleared");
        ack(0, 0, 1, "R4 empty read");

        // R2: tie on level, then higher level
        cfg(2, 1'b1, 4); cfg(5, 1'b1, 4);
        req(8'h24);
        ack(2, 4, 0, "R2 tie lower number");
        ack(5, 4, 0, "R2 tie second");
        cfg(6, 1'b1, 6); cfg(1, 1'b1, 2);
        req(8'h42);
        ack(6, 6, 0, "R2 higher level");
        ack(1, 2, 0, "R2 lower level");

        // R5: disabled and level-zero sources
        cfg(4, 1'b0, 7); cfg(7, 1'b1, 0);
        req(8'h90);
        check(int'(irq_o), 0, "R5 disabled no irq");
        ack(0, 0, 1, "R5 disabled not acked");
        cfg(4, 1'b1, 7);
        check(int'(irq_o), 1, "R5 kept pending");
        ack(4, 7, 0, "R5 acked after enable");
        cfg(7, 1'b1, 1);
        ack(7, 1, 0, "R5 level zero kept pending");

        // R7: short low pulse ignored
        nmi_phase(1'b0, Q - 1);
        nmi_phase(1'b1, 6);
        ack(0, 0, 1, "R7 short low ignored");

        // R6 / R10 / R11: qualified NMI beats maskable
        req(8'h08);
        nmi_pin_i = 1'b0;
        tick(3);
        check(int'(nmi_lvl_o), 0, "R11 level low");
        stop_wr_i = 1'b1; stop_wdata_i = 1'b1; tick(); stop_wr_i = 1'b0;
        tick();
        check(int'(stop_en_o), 0, "R10 stop forced low");
        tick(4);
        ack(N, (1 << PW) - 1, 0, "R6 nmi wins");
        ack(3, 5, 0, "R6 maskable after nmi");

        // R7: short high glitch during low phase, no second NMI
        nmi_phase(1'b1, Q - 1);
        nmi_phase(1'b0, 8);
        ack(0, 0, 1, "R7 short high ignored");
        nmi_phase(1'b1, 8);
        stop_wr_i = 1'b1; stop_wdata_i = 1'b1; tick(); stop_wr_i = 1'b0;
        check(int'(stop_en_o), 1, "R10 stop write accepted");
        nmi_phase(1'b0, 8);
        ack(N, (1 << PW) - 1, 0, "R6 nmi after full high");
        nmi_phase(1'b1, 8);

        // Randomized stretch against the model
        for (int c = 0; c < 3000; c++) begin
            irq_req_i    = N'($urandom & $urandom);
            cfg_wr_i     = ($urandom % 6) == 0;
            cfg_idx_i    = IW'($urandom);
            cfg_en_i     = ($urandom % 4) != 0;
            cfg_lvl_i    = PW'($urandom);
            ack_rd_i     = ($urandom % 3) == 0;
            stop_wr_i    = ($urandom % 5) == 0;
            stop_wdata_i = 1'($urandom);
            if (($urandom % 4) == 0) nmi_pin_i = ~nmi_pin_i;
            tick();
        end
        irq_req_i = '0; cfg_wr_i = 1'b0; ack_rd_i = 1'b0; stop_wr_i = 1'b0;
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule